// File: doc/BRIEF.md
# LCD Controller Command Interpreter

This block sits behind the host bus of a dot-matrix LCD controller and turns a stream of command bytes into the controller's internal settings. Each byte arrives with a one-cycle valid strobe. Most commands are a single byte whose low bits carry the operand. Four commands take two bytes: the first byte names the target setting and the next valid byte carries its value. That value is checked against the legal range before it is stored.

The settings are driven continuously on output ports for the scan, bias and power logic. These settings are the RAM column pointer, the master or slave role, the regulator gain step, three power enables, the first displayed RAM row, the COM0 row mapping, the number of multiplexed lines, the N-line inversion code and the bias/mux select. The column pointer is assembled from two separate commands, one for its low nibble and one for its upper bits. A setting changes on the clock edge that accepts its final byte.

Top module: `lcdcmd_top`

## Requirements
- R1: After reset these outputs are zero: column pointer, slave select, regulator ratio, all three power enables, start line, display offset and N-line inversion code. The multiplexed line count is ROWS (160 by default) and the bias select is 3'b110.
- R2: Opcode 0x00–0x0F loads byte[3:0] into colAddr[3:0]. Opcode 0x10–0x17 loads byte[2:0] into the column pointer bits above the low nibble. Each of these opcodes leaves the other part of the pointer unchanged.
- R3: Opcode 0x18 clears slaveMode (master) and opcode 0x19 sets it.
- R4: Opcode 0x20–0x27 loads byte[2:0] into regRatio.
- R5: Opcode 0x28–0x2F loads the power enables from the opcode bits: bit 2 to boostEn, bit 1 to regEn and bit 0 to bufEn.
- R6: Opcode 0x50–0x57 loads byte[2:0] into biasSel when byte[0] is 0 (codes 000, 010, 100, 110). An odd code leaves biasSel unchanged.
- R7: Four opcode groups select a two-byte command: 0x40–0x43 selects start line, 0x44–0x47 display offset, 0x48–0x4B multiplexed line count and 0x4C–0x4F N-line inversion code. The next valid byte is always taken as the value, whatever it encodes. The byte after that is decoded as an opcode again.
- R8: A start-line or display-offset value from 0 to ROWS-1 is stored. A larger value is discarded and the previous setting is kept.
- R9: A multiplexed line count from 16 to ROWS is stored. Any other value is discarded and the previous setting is kept.
- R10: An N-line inversion value from 0 to 31 is stored in nInvCode, where 0 means inversion off. A larger value is discarded and the previous setting is kept.
- R11: Opcodes 0x1A–0x1F, 0x30–0x3F and 0x58–0xFF change no output. The byte that follows them is decoded as an opcode.
- R12: While cmdValid is low, no output changes and a pending two-byte command keeps waiting for its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | cmdByte is consumed on this edge |
| cmdByte | input | 8 | Command or parameter byte |
| colAddr | output | 4+COL_HI_BITS | RAM column pointer |
| slaveMode | output | 1 | 1 = slave role, 0 = master |
| regRatio | output | 3 | Regulator gain step |
| boostEn | output | 1 | Voltage booster enable |
| regEn | output | 1 | Regulator enable |
| bufEn | output | 1 | Output buffer enable |
| startLine | output | clog2(ROWS+1) | First RAM row shown |
| dispOffset | output | clog2(ROWS+1) | RAM row mapped to COM0 |
| muxLines | output | clog2(ROWS+1) | Number of multiplexed lines |
| nInvCode | output | 5 | N-line inversion code, 0 = off |
| biasSel | output | 3 | Bias/mux select code |

## Verification
The bench builds the block with its default parameters: ROWS of 160, a 16-line multiplex minimum and three upper column bits. With these values the edges of every range check can be reached directly: 159 and 160 for the row settings, 15, 16, 160 and 161 for the line count, and a full 7-bit column pointer. Parameter bytes are chosen to look like live opcodes, so that a byte taken as an opcode instead of a value shows up on an unrelated output. Idle gaps are placed inside a pending two-byte command to show that the command keeps waiting for its value.

// File: rtl/lcdcmd_pkg.sv
package lcdcmd_pkg;

  // Which register a pending two-byte command will write
  typedef enum logic [2:0] {
    ST_OPCODE = 3'd0,
    ST_START  = 3'd1,
    ST_OFFSET = 3'd2,
    ST_MUX    = 3'd3,
    ST_NINV   = 3'd4
  } cmdState_t;

  // Strobes from control to datapath, plus the byte they apply to
  typedef struct packed {
    logic       colLo;
    logic       colHi;
    logic       ms;
    logic       ratio;
    logic       pwr;
    logic       bias;
    logic       start;
    logic       offset;
    logic       mux;
    logic       ninv;
    logic [7:0] data;
  } lcdStrobes_t;

  localparam int STROBE_COUNT = 10;

  // Reserved opcode ranges; written independently of the decoder
  function automatic logic isReserved(input logic [7:0] b);
    return ((b >= 8'h1A) && (b <= 8'h1F)) ||
           ((b >= 8'h30) && (b <= 8'h3F)) ||
           (b >= 8'h58);
  endfunction

endpackage

// File: rtl/lcdcmd_ctrl.sv
module lcdcmd_ctrl
  import lcdcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [7:0]  cmdByte,
  output lcdStrobes_t strb,
  output logic        awaitParam
);

  cmdState_t state, stateNext;
  logic [STROBE_COUNT-1:0] strobeVec;

  always_comb begin
    strb      = '0;
    strb.data = cmdByte;
    stateNext = state;
    if (cmdValid) begin
      unique case (state)
        ST_OPCODE: begin
          if (cmdByte[7:4] == 4'h0)                strb.colLo = 1'b1;
          else if (cmdByte[7:3] == 5'b00010)       strb.colHi = 1'b1;
          else if (cmdByte[7:1] == 7'b0001100)     strb.ms    = 1'b1;
          else if (cmdByte[7:3] == 5'b00100)       strb.ratio = 1'b1;
          else if (cmdByte[7:3] == 5'b00101)       strb.pwr   = 1'b1;
          else if (cmdByte[7:2] == 6'b010000)      stateNext  = ST_START;
          else if (cmdByte[7:2] == 6'b010001)      stateNext  = ST_OFFSET;
          else if (cmdByte[7:2] == 6'b010010)      stateNext  = ST_MUX;
          else if (cmdByte[7:2] == 6'b010011)      stateNext  = ST_NINV;
          else if (cmdByte[7:3] == 5'b01010)       strb.bias  = 1'b1;
        end
        ST_START:  begin strb.start  = 1'b1; stateNext = ST_OPCODE; end
        ST_OFFSET: begin strb.offset = 1'b1; stateNext = ST_OPCODE; end
        ST_MUX:    begin strb.mux    = 1'b1; stateNext = ST_OPCODE; end
        ST_NINV:   begin strb.ninv   = 1'b1; stateNext = ST_OPCODE; end
        default:   stateNext = ST_OPCODE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OPCODE;
    else       state <= stateNext;
  end

  assign awaitParam = (state != ST_OPCODE);
  assign strobeVec  = {strb.colLo, strb.colHi, strb.ms, strb.ratio, strb.pwr,
                       strb.bias, strb.start, strb.offset, strb.mux, strb.ninv};

  AST_PARAM_ONE_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (awaitParam && cmdValid) |=> !awaitParam); // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobeVec)); // R7
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (strobeVec == '0)); // R12
  AST_WAIT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid && awaitParam) |=> awaitParam); // R12

endmodule

// File: rtl/lcdcmd_rangereg.sv
module lcdcmd_rangereg #(
  parameter int W   = 8,
  parameter int LO  = 0,
  parameter int HI  = 159,
  parameter int RST = 0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ld,
  input  logic [7:0]   din,
  output logic [W-1:0] q
);

  localparam logic [7:0]   LO8  = LO[7:0];
  localparam logic [7:0]   HI8  = HI[7:0];
  localparam logic [W-1:0] RSTW = RST[W-1:0];

  logic lowOk, highOk, accept;

  generate
    if (LO == 0) begin : g_noLow
      assign lowOk = 1'b1;
    end else begin : g_low
      assign lowOk = (din >= LO8);
    end
  endgenerate

  assign highOk = (din <= HI8);
  assign accept = ld && lowOk && highOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       q <= RSTW;
    else if (accept) q <= din[W-1:0];
  end

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (ld && !(lowOk && highOk)) |=> $stable(q)); // R8, R9, R10
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (int'(q) >= LO) && (int'(q) <= HI)); // R8, R9, R10

endmodule

// File: rtl/lcdcmd_regs.sv
module lcdcmd_regs
  import lcdcmd_pkg::*;
#(
  parameter int ROWS        = 160,
  parameter int MIN_MUX     = 16,
  parameter int COL_HI_BITS = 3,
  localparam int COL_W      = 4 + COL_HI_BITS,
  localparam int ROW_W      = $clog2(ROWS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  lcdStrobes_t      strb,
  output logic [COL_W-1:0] colAddr,
  output logic             slaveMode,
  output logic [2:0]       regRatio,
  output logic             boostEn,
  output logic             regEn,
  output logic             bufEn,
  output logic [ROW_W-1:0] startLine,
  output logic [ROW_W-1:0] dispOffset,
  output logic [ROW_W-1:0] muxLines,
  output logic [4:0]       nInvCode,
  output logic [2:0]       biasSel
);

  localparam logic [2:0] BIAS_RST = 3'b110;

  // Column pointer: two independently written parts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colAddr <= '0;
    end else begin
      if (strb.colLo) colAddr[3:0]       <= strb.data[3:0];
      if (strb.colHi) colAddr[COL_W-1:4] <= strb.data[COL_HI_BITS-1:0];
    end
  end

  // Single-byte settings with operand in the opcode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slaveMode <= 1'b0;
      regRatio  <= 3'b000;
      boostEn   <= 1'b0;
      regEn     <= 1'b0;
      bufEn     <= 1'b0;
      biasSel   <= BIAS_RST;
    end else begin
      if (strb.ms)    slaveMode <= strb.data[0];
      if (strb.ratio) regRatio  <= strb.data[2:0];
      if (strb.pwr) begin
        boostEn <= strb.data[2];
        regEn   <= strb.data[1];
        bufEn   <= strb.data[0];
      end
      if (strb.bias && !strb.data[0]) biasSel <= strb.data[2:0];
    end
  end

  // Two-byte settings, each with its own accepted range
  lcdcmd_rangereg #(.W(ROW_W), .LO(0), .HI(ROWS-1), .RST(0)) u_start (
    .clk(clk), .rstN(rstN), .ld(strb.start), .din(strb.data), .q(startLine));

  lcdcmd_rangereg #(.W(ROW_W), .LO(0), .HI(ROWS-1), .RST(0)) u_offset (
    .clk(clk), .rstN(rstN), .ld(strb.offset), .din(strb.data), .q(dispOffset));

  lcdcmd_rangereg #(.W(ROW_W), .LO(MIN_MUX), .HI(ROWS), .RST(ROWS)) u_mux (
    .clk(clk), .rstN(rstN), .ld(strb.mux), .din(strb.data), .q(muxLines));

  lcdcmd_rangereg #(.W(5), .LO(0), .HI(31), .RST(0)) u_ninv (
    .clk(clk), .rstN(rstN), .ld(strb.ninv), .din(strb.data), .q(nInvCode));

  AST_COLHI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.colHi && !strb.colLo) |=> (colAddr[3:0] == $past(colAddr[3:0]))); // R2
  AST_COLLO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rstN)
    (strb.colLo && !strb.colHi) |=> (colAddr[COL_W-1:4] == $past(colAddr[COL_W-1:4]))); // R2
  AST_BIAS_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    !biasSel[0]); // R6
  AST_PWR_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strb.pwr |=> ({boostEn, regEn, bufEn} == $past(strb.data[2:0]))); // R5

endmodule

// File: rtl/lcdcmd_top.sv
module lcdcmd_top
  import lcdcmd_pkg::*;
#(
  parameter int ROWS        = 160,
  parameter int MIN_MUX     = 16,
  parameter int COL_HI_BITS = 3,
  localparam int COL_W      = 4 + COL_HI_BITS,
  localparam int ROW_W      = $clog2(ROWS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [7:0]       cmdByte,
  output logic [COL_W-1:0] colAddr,
  output logic             slaveMode,
  output logic [2:0]       regRatio,
  output logic             boostEn,
  output logic             regEn,
  output logic             bufEn,
  output logic [ROW_W-1:0] startLine,
  output logic [ROW_W-1:0] dispOffset,
  output logic [ROW_W-1:0] muxLines,
  output logic [4:0]       nInvCode,
  output logic [2:0]       biasSel
);

  lcdStrobes_t strb;
  logic        awaitParam;

  lcdcmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .strb(strb), .awaitParam(awaitParam));

  lcdcmd_regs #(.ROWS(ROWS), .MIN_MUX(MIN_MUX), .COL_HI_BITS(COL_HI_BITS)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb),
    .colAddr(colAddr), .slaveMode(slaveMode), .regRatio(regRatio),
    .boostEn(boostEn), .regEn(regEn), .bufEn(bufEn),
    .startLine(startLine), .dispOffset(dispOffset), .muxLines(muxLines),
    .nInvCode(nInvCode), .biasSel(biasSel));

  logic [COL_W+3*ROW_W+15-1:0] allOut;
  assign allOut = {colAddr, slaveMode, regRatio, boostEn, regEn, bufEn,
                   startLine, dispOffset, muxLines, nInvCode, biasSel};

  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !awaitParam && isReserved(cmdByte)) |=> ($stable(allOut) && !awaitParam)); // R11
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> $stable(allOut)); // R12

endmodule

// File: tb/sim_lcdcmd_top.sv
module sim_lcdcmd_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdByte = 8'h00;
  logic [6:0] colAddr;
  logic       slaveMode;
  logic [2:0] regRatio;
  logic       boostEn, regEn, bufEn;
  logic [7:0] startLine, dispOffset, muxLines;
  logic [4:0] nInvCode;
  logic [2:0] biasSel;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // expected state
  logic [6:0] eCol;
  logic       eSlave;
  logic [2:0] eRatio;
  logic [2:0] ePwr;
  logic [7:0] eStart, eOffset, eMux;
  logic [4:0] eNinv;
  logic [2:0] eBias;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcdcmd_top u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .colAddr(colAddr), .slaveMode(slaveMode), .regRatio(regRatio),
    .boostEn(boostEn), .regEn(regEn), .bufEn(bufEn),
    .startLine(startLine), .dispOffset(dispOffset), .muxLines(muxLines),
    .nInvCode(nInvCode), .biasSel(biasSel));

  task automatic cmp(input string req, input string field, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual %0d expected %0d", req, field, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    cmp(req, "colAddr", int'(colAddr), int'(eCol));
    cmp(req, "slaveMode", int'(slaveMode), int'(eSlave));
    cmp(req, "regRatio", int'(regRatio), int'(eRatio));
    cmp(req, "power", int'({boostEn, regEn, bufEn}), int'(ePwr));
    cmp(req, "startLine", int'(startLine), int'(eStart));
    cmp(req, "dispOffset", int'(dispOffset), int'(eOffset));
    cmp(req, "muxLines", int'(muxLines), int'(eMux));
    cmp(req, "nInvCode", int'(nInvCode), int'(eNinv));
    cmp(req, "biasSel", int'(biasSel), int'(eBias));
  endtask

  // Present one byte for one edge; returns at the following negedge
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdByte  = b;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic t_reset;
    eCol = '0; eSlave = 0; eRatio = 0; ePwr = 0;
    eStart = 0; eOffset = 0; eMux = 8'd160; eNinv = 0; eBias = 3'b110;
    checkAll("R1");
  endtask

  task automatic t_column;
    sendByte(8'h0A); eCol = 7'h0A; checkAll("R2");
    sendByte(8'h15); eCol = 7'h5A; checkAll("R2");
    sendByte(8'h03); eCol = 7'h53; checkAll("R2");
    sendByte(8'h17); eCol = 7'h73; checkAll("R2");
    sendByte(8'h0F); eCol = 7'h7F; checkAll("R2");
  endtask

  task automatic t_mode;
    sendByte(8'h19); eSlave = 1; checkAll("R3");
    sendByte(8'h18); eSlave = 0; checkAll("R3");
  endtask

  task automatic t_ratio;
    sendByte(8'h25); eRatio = 3'd5; checkAll("R4");
    sendByte(8'h27); eRatio = 3'd7; checkAll("R4");
  endtask

  task automatic t_power;
    sendByte(8'h2C); ePwr = 3'b100; checkAll("R5");
    sendByte(8'h2B); ePwr = 3'b011; checkAll("R5");
    sendByte(8'h28); ePwr = 3'b000; checkAll("R5");
  endtask

  task automatic t_bias;
    sendByte(8'h52); eBias = 3'b010; checkAll("R6");
    sendByte(8'h55); checkAll("R6");
    sendByte(8'h50); eBias = 3'b000; checkAll("R6");
    sendByte(8'h56); eBias = 3'b110; checkAll("R6");
  endtask

  task automatic t_twoByte;
    sendByte(8'h40); checkAll("R7");
    sendByte(8'h12); eStart = 8'h12; checkAll("R7");
    sendByte(8'h45); sendByte(8'h2A); eOffset = 8'h2A; checkAll("R7");
    sendByte(8'h29); ePwr = 3'b001; checkAll("R7");
    sendByte(8'h4B); sendByte(8'h19); eMux = 8'h19; checkAll("R7");
    sendByte(8'h4C); sendByte(8'h05); eNinv = 5'd5; checkAll("R7");
  endtask

  task automatic t_rowRange;
    sendByte(8'h41); sendByte(8'd159); eStart = 8'd159; checkAll("R8");
    sendByte(8'h40); sendByte(8'd160); checkAll("R8");
    sendByte(8'h44); sendByte(8'd159); eOffset = 8'd159; checkAll("R8");
    sendByte(8'h44); sendByte(8'd200); checkAll("R8");
    sendByte(8'h44); sendByte(8'd0); eOffset = 8'd0; checkAll("R8");
  endtask

  task automatic t_muxRange;
    sendByte(8'h48); sendByte(8'd16); eMux = 8'd16; checkAll("R9");
    sendByte(8'h48); sendByte(8'd15); checkAll("R9");
    sendByte(8'h48); sendByte(8'd160); eMux = 8'd160; checkAll("R9");
    sendByte(8'h48); sendByte(8'd161); checkAll("R9");
    sendByte(8'h48); sendByte(8'd64); eMux = 8'd64; checkAll("R9");
  endtask

  task automatic t_ninvRange;
    sendByte(8'h4F); sendByte(8'd31); eNinv = 5'd31; checkAll("R10");
    sendByte(8'h4C); sendByte(8'd32); checkAll("R10");
    sendByte(8'h4C); sendByte(8'd0); eNinv = 5'd0; checkAll("R10");
  endtask

  task automatic t_reserved;
    logic [7:0] rsv [7] = '{8'h1A, 8'h1F, 8'h30, 8'h3F, 8'h58, 8'h5F, 8'hFF};
    for (int i = 0; i < 7; i++) begin
      sendByte(rsv[i]); checkAll("R11");
    end
    sendByte(8'h06); eCol = {eCol[6:4], 4'h6}; checkAll("R11");
  endtask

  task automatic t_idleWait;
    sendByte(8'h48);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cmdByte = 8'h0F - 8'(i);
      @(negedge clk);
      checkAll("R12");
    end
    sendByte(8'h20); eMux = 8'd32; checkAll("R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_column();
    t_mode();
    t_ratio();
    t_power();
    t_bias();
    t_twoByte();
    t_rowRange();
    t_muxRange();
    t_ninvRange();
    t_reserved();
    t_idleWait();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule